// File: doc/BRIEF.md
# Parallel FIFO Buffer with Read Rewind

This block is a single-clock first-in first-out buffer. By default it holds 1024 words of 9 bits each. A producer writes with a write strobe and a consumer reads with a read strobe. Two internal pointers generate every storage address, so no address is ever supplied from outside. The ninth data bit is stored like any other bit, which makes it suitable for carrying a parity bit.

Three flags report occupancy: empty, full and more-than-half-full. The empty flag and the full flag block the strobes that would otherwise underflow or overflow the buffer. A retransmit input moves the read side back to storage location zero without touching the write side, so a block of data that was already consumed can be read again after an error. A synchronous master clear returns the whole buffer to its empty state.

Top module: `par_fifo_rt`

## Requirements
- R1: While `clr` is high at a rising edge, the next state is: both pointers and the occupancy at zero, `empty` high, `full` and `half_full` low, and `rd_data` equal to zero.
- R2: Words come out in the order they were written, and all 9 bits are returned unchanged, including bit 8. A word appears on `rd_data` one cycle after the edge that accepts its read strobe, and it holds there until the next accepted read.
- R3: A read strobe while `empty` is high is ignored. `rd_data`, the read pointer and the flags do not change.
- R4: A write strobe while `full` is high is ignored. The words already stored are kept and later read out unchanged.
- R5: `full` is high exactly when 1024 words are stored, and `empty` is high exactly when none are stored.
- R6: `half_full` is high when at least 513 words are stored. It is low at 512 words or fewer.
- R7: A write and a read accepted at the same edge leave the occupancy unchanged, and each operation still takes effect.
- R8: When `retx` is high at an edge, the read pointer becomes zero and the write pointer keeps its behaviour (a write at that edge is still accepted). A read strobe at that edge is ignored. The occupancy becomes the new write pointer value, and reading then starts again at location zero.
- R9: Both pointers wrap from 1023 to 0, and the data order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clr | input | 1 | Synchronous master clear, active high |
| wr_stb | input | 1 | Write strobe; accepted when not full |
| wr_data | input | 9 | Word to store |
| rd_stb | input | 1 | Read strobe; accepted when not empty and no retransmit |
| retx | input | 1 | Retransmit: rewind the read pointer to zero |
| rd_data | output | 9 | Registered word from the last accepted read |
| empty | output | 1 | No words stored |
| full | output | 1 | All 1024 locations in use |
| half_full | output | 1 | More than 512 words stored |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. A word reaches `rd_data` one edge after its read strobe is accepted. All three flags follow the occupancy register, so they show a write, a read or a rewind from the edge on which that operation takes effect. The bench applies inputs at the falling edge and advances its model at the rising edge. It then compares `rd_data` and the three flags 1 ns after that rising edge, so each comparison falls in the first cycle in which the new value is due. Ignored strobes are detected because `rd_data` and the flags keep their previous model values, and because the stored data drains out unchanged later.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  localparam int DATA_W_DEF = 9;
  localparam int DEPTH_DEF  = 1024;

  typedef struct packed {
    logic empty;
    logic half;
    logic full;
  } occ_flags_t;
endpackage

// File: rtl/fifo_rt_ptr.sv
module fifo_rt_ptr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  input  logic          rewind,
  output logic [AW-1:0] ptr
);
  // wraps naturally from all-ones to zero
  function automatic logic [AW-1:0] ptr_step(logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (clr)         ptr <= '0;
    else if (rewind) ptr <= '0;
    else if (adv)    ptr <= ptr_step(ptr);
  end
endmodule

// File: rtl/fifo_rt_occ.sv
module fifo_rt_occ
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int CW    = 11
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_acc,
  input  logic          rd_acc,
  input  logic          rewind,
  input  logic [AW-1:0] wr_ptr,
  output logic [CW-1:0] count,
  output occ_flags_t    flags
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  function automatic logic [CW-1:0] occ_next(
    logic [CW-1:0] c, logic [AW-1:0] wp, logic wa, logic ra, logic rw);
    if (rw)            return {1'b0, wp} + CW'(wa);
    else if (wa && !ra) return c + CW'(1);
    else if (ra && !wa) return c - CW'(1);
    else               return c;
  endfunction

  always_ff @(posedge clk) begin
    if (clr) count <= '0;
    else     count <= occ_next(count, wr_ptr, wr_acc, rd_acc, rewind);
  end

  always_comb begin
    flags.empty = (count == '0);
    flags.full  = (count == FULL_CNT);
    flags.half  = (count > HALF_CNT);
  end
endmodule

// File: rtl/fifo_rt_ram.sv
module fifo_rt_ram #(
  parameter int DW    = 9,
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (clr)     rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/par_fifo_rt.sv
module par_fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int DW    = DATA_W_DEF,
  parameter int DEPTH = DEPTH_DEF
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_stb,
  input  logic          retx,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic          half_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ_count;
  occ_flags_t    flags;
  logic          wr_acc, rd_acc;

  // accepted events, named for the checker
  assign wr_acc = wr_stb & ~flags.full;
  assign rd_acc = rd_stb & ~flags.empty & ~retx;

  fifo_rt_ptr #(.AW(AW)) u_wptr (
    .clk(clk), .clr(clr), .adv(wr_acc), .rewind(1'b0), .ptr(wr_ptr));

  fifo_rt_ptr #(.AW(AW)) u_rptr (
    .clk(clk), .clr(clr), .adv(rd_acc), .rewind(retx), .ptr(rd_ptr));

  fifo_rt_occ #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_occ (
    .clk(clk), .clr(clr), .wr_acc(wr_acc), .rd_acc(rd_acc),
    .rewind(retx), .wr_ptr(wr_ptr), .count(occ_count), .flags(flags));

  fifo_rt_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .clr(clr), .we(wr_acc), .waddr(wr_ptr), .wdata(wr_data),
    .re(rd_acc), .raddr(rd_ptr), .rdata(rd_data));

  assign empty     = flags.empty;
  assign full      = flags.full;
  assign half_full = flags.half;
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int DW = 9,
  parameter int AW = 10,
  parameter int CW = 11
) (
  input logic          clk,
  input logic          clr,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic          retx,
  input logic [DW-1:0] rd_data,
  input logic          empty,
  input logic          full,
  input logic          half_full,
  input logic          wr_acc,
  input logic          rd_acc,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [CW-1:0] occ_count
);
  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (clr)
    !(empty && full));

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (clr)
    (empty && !wr_stb && !retx) |=> (empty && $stable(rd_data) && $stable(rd_ptr)));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (clr)
    (full && !rd_stb && !retx) |=> (full && $stable(wr_ptr)));

  // R6
  half_with_full_chk: assert property (@(posedge clk) disable iff (clr)
    full |-> half_full);

  // R7
  both_ops_count_chk: assert property (@(posedge clk) disable iff (clr)
    (wr_acc && rd_acc) |=> $stable(occ_count));

  // R8
  rewind_ptr_chk: assert property (@(posedge clk) disable iff (clr)
    retx |=> (rd_ptr == '0));

  // R8
  rewind_keeps_wr_chk: assert property (@(posedge clk) disable iff (clr)
    (retx && !wr_acc) |=> $stable(wr_ptr));

  // R2
  hold_data_chk: assert property (@(posedge clk) disable iff (clr)
    !rd_acc |=> $stable(rd_data));
endmodule

bind par_fifo_rt fifo_rt_chk #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .clr(clr), .wr_stb(wr_stb), .rd_stb(rd_stb), .retx(retx),
  .rd_data(rd_data), .empty(empty), .full(full), .half_full(half_full),
  .wr_acc(wr_acc), .rd_acc(rd_acc), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .occ_count(occ_count));

// File: tb/test_par_fifo_rt.sv
module test_par_fifo_rt;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 9;
  localparam int DEPTH = 1024;

  logic          clk = 1'b0;
  logic          clr = 1'b1;
  logic          wr_stb = 1'b0, rd_stb = 1'b0, retx = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          empty, full, half_full;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_fifo_rt i_par_fifo_rt (
    .clk(clk), .clr(clr), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .retx(retx), .rd_data(rd_data),
    .empty(empty), .full(full), .half_full(half_full));

  int    n_chk = 0, n_bad = 0;
  string tag = "R1";

  // behavioural reference
  int m_mem[DEPTH];
  int m_wp = 0, m_rp = 0, m_cnt = 0, m_dout = 0;

  task automatic cmp(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp("rd_data", int'(rd_data), m_dout);
    cmp("empty", int'(empty), int'(m_cnt == 0));
    cmp("full", int'(full), int'(m_cnt == DEPTH));
    cmp("half_full", int'(half_full), int'(m_cnt > DEPTH/2));
  endtask

  task automatic do_reset();
    @(negedge clk);
    clr = 1'b1; wr_stb = 1'b0; rd_stb = 1'b0; retx = 1'b0;
    repeat (3) @(posedge clk);
    m_wp = 0; m_rp = 0; m_cnt = 0; m_dout = 0;
    #1;
    tag = "R1";
    compare_all();
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic cycle(bit w, int d, bit r, bit rt);
    bit wa, ra;
    int old_wp;
    @(negedge clk);
    wr_stb = w; wr_data = d[DW-1:0]; rd_stb = r; retx = rt;
    @(posedge clk);
    wa = w && (m_cnt < DEPTH);
    old_wp = m_wp;
    if (rt) begin
      if (wa) begin m_mem[m_wp] = d % 512; m_wp = (m_wp + 1) % DEPTH; end
      m_rp  = 0;
      m_cnt = old_wp + int'(wa);
    end else begin
      ra = r && (m_cnt > 0);
      if (ra) begin m_dout = m_mem[m_rp]; m_rp = (m_rp + 1) % DEPTH; end
      if (wa) begin m_mem[m_wp] = d % 512; m_wp = (m_wp + 1) % DEPTH; end
      m_cnt = m_cnt + int'(wa) - int'(ra);
    end
    #1;
    compare_all();
  endtask

  function automatic int pat(int i);
    return (i * 37 + 5) % 512;
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired in phase %s", tag);
    summary();
    $finish;
  end

  initial begin
    do_reset();

    // R2: order and ninth bit
    tag = "R2";
    cycle(1, 9'h1FF, 0, 0);
    cycle(1, 9'h100, 0, 0);
    cycle(1, 9'h0FF, 0, 0);
    cycle(1, 9'h0A5, 0, 0);
    for (int i = 0; i < 5; i++) cycle(0, 0, 1, 0);

    // R3: reads while empty
    tag = "R3";
    for (int i = 0; i < 3; i++) cycle(0, 0, 1, 0);

    // R7: simultaneous read and write
    tag = "R7";
    cycle(1, 9'h033, 0, 0);
    for (int i = 0; i < 8; i++) cycle(1, pat(i), 1, 0);
    cycle(0, 0, 1, 0);

    // R6: half threshold
    do_reset();
    tag = "R6";
    for (int i = 0; i < DEPTH/2; i++) cycle(1, pat(i + 100), 0, 0);
    cycle(1, 9'h155, 0, 0);
    cycle(0, 0, 1, 0);
    cycle(1, 9'h0AA, 0, 0);

    // R5 and R4: fill, overfill
    tag = "R5";
    while (m_cnt < DEPTH) cycle(1, pat(m_cnt + 7), 0, 0);
    tag = "R4";
    cycle(1, 9'h1EE, 0, 0);
    cycle(1, 9'h011, 0, 0);

    // R9: drain past the wrap, then stream across it again
    tag = "R9";
    for (int i = 0; i < DEPTH; i++) cycle(0, 0, 1, 0);
    cycle(0, 0, 1, 0);
    for (int i = 0; i < 40; i++) cycle(1, pat(i + 300), i > 2, 0);
    while (m_cnt > 0) cycle(0, 0, 1, 0);

    // R8: retransmit
    do_reset();
    tag = "R8";
    for (int i = 0; i < 6; i++) cycle(1, pat(i + 50) | 256, 0, 0);
    for (int i = 0; i < 3; i++) cycle(0, 0, 1, 0);
    cycle(0, 0, 1, 1);
    cycle(1, 9'h0C3, 0, 1);
    for (int i = 0; i < 8; i++) cycle(0, 0, 1, 0);

    summary();
    $finish;
  end
endmodule